// File: doc/BRIEF.md
# Arithmetic-Logic Unit with Operation Decoder

This block is the execute-stage arithmetic unit of a simple 32-bit integer core. A two-bit operation class from the main instruction decoder and the six-bit function field of register-format instructions are turned into a three-bit ALU control word. That word drives a single shared adder and a small result selector which together perform bitwise AND, bitwise OR, addition, subtraction and signed set-on-less-than on two operands.

Subtraction and set-on-less-than share the adder used by addition: the top bit of the control word inverts operand B and forces a carry-in of one, so the adder forms A minus B. The low two bits of the control word pick which result reaches the output. A zero flag (used for branch-on-equal) and a signed overflow flag accompany the result. The block holds no state; all outputs follow the inputs combinationally.

Top module: `alu_unit`

## Requirements
- R1: With operation class 00 the control word is 010 (add) whatever the function field holds, and the result is A plus B modulo 2^32.
- R2: With operation class 01 the control word is 110 (subtract) whatever the function field holds, and the result is A minus B modulo 2^32.
- R3: With operation class 10 the function field is decoded: 100100 gives 000 (AND), 100101 gives 001 (OR), 100000 gives 010 (add), 100010 gives 110 (subtract), 101010 gives 111 (set-on-less-than).
- R4: Any other function value under class 10, and every function value under the unused class 11, gives control word 010 (add).
- R5: Control word 000 returns A AND B bitwise; control word 001 returns A OR B bitwise.
- R6: Control words 010 and 110 return A plus B and A minus B respectively, modulo 2^32.
- R7: Control word 111 returns 1 in bit 0 and 0 in bits 31..1 when A is less than B as two's-complement numbers, and all zeros otherwise, including when A minus B overflows.
- R8: The zero output is 1 exactly when all 32 result bits are 0; for subtraction it is 1 exactly when A equals B.
- R9: The overflow output is 1 for add and subtract exactly when the true signed result does not fit in 32 bits, and is 0 for AND, OR and set-on-less-than.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| alu_op | input | 2 | Operation class from the main decoder |
| funct | input | 6 | Function field of the instruction |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| alu_ctl | output | 3 | Decoded control word: bit 2 negates B, bits 1..0 select the result |
| result | output | 32 | Operation result |
| zero | output | 1 | Result is all zeros |
| ovf | output | 1 | Signed overflow of add or subtract |

## Verification
Since nothing is stored, a wrong decode or a wrong adder input shows on the very same input vector that triggers it: the control word and result differ from the arithmetic expectation as soon as the inputs settle. A decoder slip appears on a specific function code, so every class and function combination is swept; an error in the negate path or the overflow correction appears only near the sign boundaries, so the operand sweep crosses all pairs of extreme and small values in both signs and adds pseudo-random pairs.

// File: rtl/alu_pkg.sv
package alu_pkg;

  localparam int OP_W    = 2;
  localparam int FUNCT_W = 6;
  localparam int CTL_W   = 3;

  typedef enum logic [1:0] {
    SEL_AND = 2'b00,
    SEL_OR  = 2'b01,
    SEL_SUM = 2'b10,
    SEL_SLT = 2'b11
  } alu_sel_e;

  typedef struct packed {
    logic     bneg;
    alu_sel_e sel;
  } alu_ctl_t;

  localparam logic [OP_W-1:0] CLS_MEM  = 2'b00;
  localparam logic [OP_W-1:0] CLS_BRCH = 2'b01;
  localparam logic [OP_W-1:0] CLS_REG  = 2'b10;

  localparam logic [FUNCT_W-1:0] FN_AND = 6'b100100;
  localparam logic [FUNCT_W-1:0] FN_OR  = 6'b100101;
  localparam logic [FUNCT_W-1:0] FN_ADD = 6'b100000;
  localparam logic [FUNCT_W-1:0] FN_SUB = 6'b100010;
  localparam logic [FUNCT_W-1:0] FN_SLT = 6'b101010;

  localparam alu_ctl_t CTL_AND = '{bneg: 1'b0, sel: SEL_AND};
  localparam alu_ctl_t CTL_OR  = '{bneg: 1'b0, sel: SEL_OR};
  localparam alu_ctl_t CTL_ADD = '{bneg: 1'b0, sel: SEL_SUM};
  localparam alu_ctl_t CTL_SUB = '{bneg: 1'b1, sel: SEL_SUM};
  localparam alu_ctl_t CTL_SLT = '{bneg: 1'b1, sel: SEL_SLT};

endpackage

// File: rtl/alu_ctl_dec.sv
module alu_ctl_dec
  import alu_pkg::*;
(
  input  logic [OP_W-1:0]    alu_op,
  input  logic [FUNCT_W-1:0] funct,
  output alu_ctl_t           ctl
);

  always_comb begin
    ctl = CTL_ADD;
    case (alu_op)
      CLS_MEM:  ctl = CTL_ADD;
      CLS_BRCH: ctl = CTL_SUB;
      CLS_REG: begin
        case (funct)
          FN_AND:  ctl = CTL_AND;
          FN_OR:   ctl = CTL_OR;
          FN_ADD:  ctl = CTL_ADD;
          FN_SUB:  ctl = CTL_SUB;
          FN_SLT:  ctl = CTL_SLT;
          default: ctl = CTL_ADD;
        endcase
      end
      default:  ctl = CTL_ADD;
    endcase

    // R1: memory class never depends on funct
    assert_memcls_add_R1: assert (alu_op != CLS_MEM || ctl == CTL_ADD)
      else $error("memory class did not decode to add");
    // R2: branch class always subtracts
    assert_brcls_sub_R2: assert (alu_op != CLS_BRCH || ctl == CTL_SUB)
      else $error("branch class did not decode to subtract");
    // R4: unused class falls back to add
    assert_spare_add_R4: assert (alu_op != 2'b11 || ctl == CTL_ADD)
      else $error("unused class did not decode to add");
    // R3: the control word 011 is never produced
    assert_no_illegal_ctl_R3: assert (!(ctl.bneg == 1'b0 && ctl.sel == SEL_SLT))
      else $error("illegal control word produced");
  end

endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  input  logic             bneg,
  output logic [WIDTH-1:0] sum,
  output logic             sum_ovf
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] b_eff;
  logic [WIDTH-1:0] cin;

  always_comb begin
    b_eff   = opnd_b ^ {WIDTH{bneg}};
    cin     = {{(WIDTH-1){1'b0}}, bneg};
    sum     = opnd_a + b_eff + cin;
    sum_ovf = (opnd_a[MSB] == b_eff[MSB]) && (sum[MSB] != opnd_a[MSB]);

    // R8: equal operands under subtraction give an all-zero sum
    assert_equal_sub_zero_R8: assert (!(bneg && opnd_a == opnd_b) || sum == '0)
      else $error("subtract of equal operands not zero");
    // R9: operands of opposite sign cannot overflow an addition
    assert_mixed_sign_noovf_R9: assert (bneg || opnd_a[MSB] == opnd_b[MSB] || !sum_ovf)
      else $error("overflow on mixed-sign addition");
  end

endmodule

// File: rtl/alu_result_sel.sv
module alu_result_sel
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  input  alu_sel_e         sel,
  input  logic [WIDTH-1:0] sum,
  input  logic             sum_ovf,
  output logic [WIDTH-1:0] result,
  output logic             zero,
  output logic             ovf
);

  localparam int MSB = WIDTH - 1;

  logic less;

  always_comb begin
    less = sum[MSB] ^ sum_ovf;
    case (sel)
      SEL_AND: result = opnd_a & opnd_b;
      SEL_OR:  result = opnd_a | opnd_b;
      SEL_SUM: result = sum;
      default: result = {{(WIDTH-1){1'b0}}, less};
    endcase
    ovf  = (sel == SEL_SUM) ? sum_ovf : 1'b0;
    zero = (result == '0);

    // R7: set-on-less-than drives only bit 0
    assert_slt_narrow_R7: assert (sel != SEL_SLT || result[MSB:1] == '0)
      else $error("slt result wider than one bit");
    // R5: AND result sets no bit absent from A
    assert_and_subset_R5: assert (sel != SEL_AND || (result & ~opnd_a) == '0)
      else $error("AND result has bit not in A");
    // R5: OR result keeps every bit of B
    assert_or_superset_R5: assert (sel != SEL_OR || (opnd_b & ~result) == '0)
      else $error("OR result lost a bit of B");
    // R9: overflow only reported for arithmetic results
    assert_no_overflow_R9: assert (sel == SEL_SUM || !ovf)
      else $error("overflow flagged on non-arithmetic op");
  end

endmodule

// File: rtl/alu_unit.sv
module alu_unit
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [OP_W-1:0]    alu_op,
  input  logic [FUNCT_W-1:0] funct,
  input  logic [WIDTH-1:0]   opnd_a,
  input  logic [WIDTH-1:0]   opnd_b,
  output logic [CTL_W-1:0]   alu_ctl,
  output logic [WIDTH-1:0]   result,
  output logic               zero,
  output logic               ovf
);

  alu_ctl_t         ctl;
  logic [WIDTH-1:0] sum;
  logic             sum_ovf;

  alu_ctl_dec u_dec (
    .alu_op (alu_op),
    .funct  (funct),
    .ctl    (ctl)
  );

  alu_addsub #(.WIDTH(WIDTH)) u_addsub (
    .opnd_a  (opnd_a),
    .opnd_b  (opnd_b),
    .bneg    (ctl.bneg),
    .sum     (sum),
    .sum_ovf (sum_ovf)
  );

  alu_result_sel #(.WIDTH(WIDTH)) u_sel (
    .opnd_a  (opnd_a),
    .opnd_b  (opnd_b),
    .sel     (ctl.sel),
    .sum     (sum),
    .sum_ovf (sum_ovf),
    .result  (result),
    .zero    (zero),
    .ovf     (ovf)
  );

  assign alu_ctl = ctl;

endmodule

// File: tb/alu_unit_bench.sv
module alu_unit_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WDOG_LIMIT = 50000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  alu_op;
  logic [5:0]  funct;
  logic [31:0] opnd_a, opnd_b;
  logic [2:0]  alu_ctl;
  logic [31:0] result;
  logic        zero, ovf;

  int total = 0;
  int bad   = 0;
  int wdog  = 0;
  bit done  = 1'b0;

  alu_unit u_alu_unit (
    .alu_op (alu_op), .funct (funct), .opnd_a (opnd_a), .opnd_b (opnd_b),
    .alu_ctl(alu_ctl), .result (result), .zero (zero), .ovf (ovf)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (rst) wdog <= 0;
    else if (!done) begin
      wdog <= wdog + 1;
      if (wdog >= WDOG_LIMIT) begin
        bad = bad + 1;
        total = total + 1;
        $display("FAIL watchdog: actual=%0d expected<%0d", wdog, WDOG_LIMIT);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total = total + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s: actual=%h expected=%h (op=%b fn=%b a=%h b=%h)",
               tag, act, exp, alu_op, funct, opnd_a, opnd_b);
    end
  endtask

  function automatic logic [2:0] exp_ctl(input logic [1:0] op, input logic [5:0] fn);
    if (op == 2'b00) return 3'b010;
    if (op == 2'b01) return 3'b110;
    if (op == 2'b11) return 3'b010;
    case (fn)
      6'b100100: return 3'b000;
      6'b100101: return 3'b001;
      6'b100000: return 3'b010;
      6'b100010: return 3'b110;
      6'b101010: return 3'b111;
      default:   return 3'b010;
    endcase
  endfunction

  function automatic logic [31:0] corner(input int i);
    case (i)
      0: return 32'h0000_0000;  1: return 32'h0000_0001;
      2: return 32'hFFFF_FFFF;  3: return 32'h7FFF_FFFF;
      4: return 32'h8000_0000;  5: return 32'h8000_0001;
      6: return 32'h7FFF_FFFE;  7: return 32'h0000_0002;
      8: return 32'hFFFF_FFFE;  9: return 32'h5555_5555;
      10: return 32'hAAAA_AAAA; default: return 32'h1234_5678;
    endcase
  endfunction

  // Expected result/ovf computed arithmetically from signed integers
  task automatic check_op(input logic [5:0] fn, input logic [31:0] a, input logic [31:0] b);
    longint sa, sb, full;
    logic [31:0] er;
    logic        eo;
    alu_op = 2'b10; funct = fn; opnd_a = a; opnd_b = b;
    #1;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    eo = 1'b0;
    case (fn)
      6'b100100: er = a & b;
      6'b100101: er = a | b;
      6'b100000: begin full = sa + sb; er = full[31:0];
                       eo = (full > 64'sd2147483647) || (full < -64'sd2147483648); end
      6'b100010: begin full = sa - sb; er = full[31:0];
                       eo = (full > 64'sd2147483647) || (full < -64'sd2147483648); end
      default:   er = (sa < sb) ? 32'd1 : 32'd0;
    endcase
    case (fn)
      6'b100100, 6'b100101: check("R5 logic result", result, er);
      6'b101010:            check("R7 slt result", result, er);
      default:              check("R6 arith result", result, er);
    endcase
    check("R9 overflow", {31'd0, ovf}, {31'd0, eo});
    check("R8 zero flag", {31'd0, zero}, {31'd0, (er == 32'd0)});
  endtask

  initial begin
    logic [31:0] s;
    logic [31:0] ra, rb;
    logic [5:0]  fns [5];
    alu_op = 2'b00; funct = 6'd0; opnd_a = 32'd0; opnd_b = 32'd0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);

    // Idle inputs: add of zeros
    #1;
    check("R1 idle result", result, 32'd0);
    check("R8 idle zero", {31'd0, zero}, 32'd1);

    // Sweep every class and funct: control word
    for (int op = 0; op < 4; op++) begin
      for (int fn = 0; fn < 64; fn++) begin
        alu_op = op[1:0]; funct = fn[5:0];
        opnd_a = 32'h0F0F_1234; opnd_b = 32'h0000_4321;
        #1;
        if (op == 2 && (fn == 36 || fn == 37 || fn == 32 || fn == 34 || fn == 42))
          check("R3 decode", {29'd0, alu_ctl}, {29'd0, exp_ctl(op[1:0], fn[5:0])});
        else if (op == 0)
          check("R1 decode", {29'd0, alu_ctl}, 32'd2);
        else if (op == 1)
          check("R2 decode", {29'd0, alu_ctl}, 32'd6);
        else
          check("R4 default decode", {29'd0, alu_ctl}, {29'd0, exp_ctl(op[1:0], fn[5:0])});
        if (op == 0) check("R1 add ignores funct", result, 32'h0F0F_5555);
        if (op == 1) check("R2 sub ignores funct", result, 32'h0F0E_CF13);
        if (op == 3) check("R4 spare adds", result, 32'h0F0F_5555);
      end
    end

    // Branch class: equality via zero flag
    alu_op = 2'b01; funct = 6'b111111; opnd_a = 32'hDEAD_BEEF; opnd_b = 32'hDEAD_BEEF;
    #1;
    check("R2 beq equal zero", {31'd0, zero}, 32'd1);
    opnd_b = 32'hDEAD_BEEE;
    #1;
    check("R2 beq unequal zero", {31'd0, zero}, 32'd0);
    check("R2 beq diff", result, 32'd1);

    // Operand corner cross product for each register-format operation
    fns[0] = 6'b100100; fns[1] = 6'b100101; fns[2] = 6'b100000;
    fns[3] = 6'b100010; fns[4] = 6'b101010;
    for (int k = 0; k < 5; k++)
      for (int i = 0; i < 12; i++)
        for (int j = 0; j < 12; j++)
          check_op(fns[k], corner(i), corner(j));

    // Pseudo-random operands
    s = 32'h1ACE_B00C;
    for (int n = 0; n < 400; n++) begin
      s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5); ra = s;
      s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5); rb = s;
      check_op(fns[n % 5], ra, rb);
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule